// File: doc/BRIEF.md
# MOESI Line State Snoop Controller

This block keeps the coherence state of every line of a small private cache and applies the state changes that local activity and incoming snoops cause. Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. Each state implies four attributes: valid, writable, readable and dirty. A fill installs a line as Shared or Exclusive, depending on the grant that came with it. A local write either completes in place or raises an upgrade request and waits for it to finish.

Snoops arrive as shared reads, upgrades or exclusive reads. When the line is dirty and the snoop needs data, the controller supplies the whole line itself. A dirty line hit by a shared read does not write back to memory. It moves to Owned and keeps serving later readers. The response leaves through a fixed-latency pipeline, so the interconnect sees it a set number of cycles after the snoop. A registered query port shows the state and attributes of any line.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line reads back as Invalid, and `rsp_valid`, `wr_hit` and `upg_req` are low.
- R2: `q_state` encodes I=0, S=1, E=2, O=3, M=4. `q_attr` bit 3 is valid, bit 2 writable, bit 1 readable and bit 0 dirty, giving I=0000, S=1010, E=1110, O=1011 and M=1111.
- R3: A fill with `fill_excl`=1 installs the line as E, and a fill with `fill_excl`=0 installs it as S. In both cases the line data is replaced with `fill_data`.
- R4: A local write to a line in E or M leaves the line in M with the new data. It pulses `wr_hit` in the next cycle and raises no upgrade.
- R5: A local write to a line in S or O pulses `upg_req` and leaves the state unchanged. When `upg_done` arrives, the line moves to M holding the write data.
- R6: A local write to an Invalid line, or any local write while an upgrade is pending, changes no state or data and raises neither `wr_hit` nor `upg_req`.
- R7: A shared-read snoop (`snp_kind`=0) behaves as follows. M moves to O and O stays O, both supplying the line. E moves to S and S stays S, with no supply. I is left alone.
- R8: An exclusive-read snoop (`snp_kind`=2) moves any valid line to I. It supplies the line only from M or O.
- R9: An upgrade snoop (`snp_kind`=1) moves any valid line to I and never supplies data.
- R10: A supplied response makes `rsp_valid` high for one cycle. That cycle is `RESP_DELAY` rising edges after the snoop, counting the edge that samples the snoop. `rsp_data` carries the line contents as they were when the snoop was sampled.
- R11: Only one event is applied per cycle, chosen in the order snoop, upgrade completion, fill, local write. Lower-priority events in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Fill arrives this cycle |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_excl | input | 1 | 1 = exclusive grant, 0 = shared grant |
| fill_data | input | LINE_W | Line contents delivered by the fill |
| wr_valid | input | 1 | Local full-line write |
| wr_idx | input | IDX_W | Line index of the write |
| wr_data | input | LINE_W | Write data |
| upg_done | input | 1 | Pending upgrade has completed |
| snp_valid | input | 1 | Snoop arrives this cycle |
| snp_kind | input | 2 | 0 shared read, 1 upgrade, 2 exclusive read |
| snp_idx | input | IDX_W | Line index of the snoop |
| q_idx | input | IDX_W | Line index to query |
| wr_hit | output | 1 | Local write completed without bus traffic |
| upg_req | output | 1 | Upgrade request issued |
| rsp_valid | output | 1 | Snoop data response valid |
| rsp_data | output | LINE_W | Supplied line contents |
| q_state | output | 3 | State of the queried line |
| q_attr | output | 4 | Attributes of the queried line |

## Verification
The assertions check four things on every cycle: that a shared-read snoop turns M into O, that upgrade and exclusive-read snoops leave the line Invalid, that a fill installs the state its grant implies, and that a write never reports both a hit and an upgrade. Other properties depend on time and sequence, and only the bench scenarios can show them. These include the exact latency and contents of a supplied response, and the wait between an upgrade request and its completion. They also include the way writes are dropped while an upgrade is pending, and which event wins when several arrive together.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHD = 3'd1,
    LS_EXC = 3'd2,
    LS_OWN = 3'd3,
    LS_MOD = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    SN_RD_SHARED = 2'd0,
    SN_UPGRADE   = 2'd1,
    SN_RD_EXCL   = 2'd2,
    SN_NOP       = 2'd3
  } snoop_kind_t;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_SNOOP    = 3'd1,
    EV_UPG_DONE = 3'd2,
    EV_FILL     = 3'd3,
    EV_WRITE    = 3'd4
  } line_ev_t;

  // {valid, writable, readable, dirty}
  function automatic logic [3:0] st_attr(line_st_t s);
    case (s)
      LS_SHD:  return 4'b1010;
      LS_EXC:  return 4'b1110;
      LS_OWN:  return 4'b1011;
      LS_MOD:  return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/moesi_next_state.sv
module moesi_next_state
  import moesi_pkg::*;
(
  input  line_st_t    cur,
  input  line_ev_t    ev,
  input  snoop_kind_t kind,
  input  logic        excl,
  output line_st_t    nxt,
  output logic        supply,
  output logic        hit,
  output logic        upg_issue,
  output logic        data_we
);

  always_comb begin
    nxt       = cur;
    supply    = 1'b0;
    hit       = 1'b0;
    upg_issue = 1'b0;
    data_we   = 1'b0;
    case (ev)
      EV_SNOOP: begin
        case (kind)
          SN_RD_SHARED: begin
            if (cur == LS_MOD || cur == LS_OWN) begin
              nxt    = LS_OWN;
              supply = 1'b1;
            end else if (cur == LS_EXC) begin
              nxt = LS_SHD;
            end
          end
          SN_RD_EXCL: begin
            supply = (cur == LS_MOD) || (cur == LS_OWN);
            nxt    = LS_INV;
          end
          SN_UPGRADE: nxt = LS_INV;
          default: ;
        endcase
      end
      EV_UPG_DONE: begin
        nxt     = LS_MOD;
        data_we = 1'b1;
      end
      EV_FILL: begin
        nxt     = excl ? LS_EXC : LS_SHD;
        data_we = 1'b1;
      end
      EV_WRITE: begin
        if (cur == LS_EXC || cur == LS_MOD) begin
          nxt     = LS_MOD;
          hit     = 1'b1;
          data_we = 1'b1;
        end else if (cur == LS_SHD || cur == LS_OWN) begin
          upg_issue = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_t          st_wval,
  input  logic              d_we,
  input  logic [LINE_W-1:0] d_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output line_st_t          rd_st,
  output logic [LINE_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  q_idx,
  output line_st_t          q_st,
  output line_st_t          st_all [LINES]
);

  line_st_t          st_q [LINES];
  logic [LINE_W-1:0] mem  [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
      q_st <= LS_INV;
    end else begin
      if (st_we) st_q[w_idx] <= st_wval;
      q_st <= st_q[q_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (d_we) mem[w_idx] <= d_wdata;
  end

  assign rd_st   = st_q[rd_idx];
  assign rd_data = mem[rd_idx];
  assign st_all  = st_q;

endmodule

// File: rtl/moesi_rsp_delay.sv
module moesi_rsp_delay #(
  parameter int DEPTH = 3,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q[0] <= 1'b0;
        else     v_q[0] <= in_valid;
        d_q[0] <= in_data;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= v_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];

endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int LINE_W     = 64,
  parameter int RESP_DELAY = 3,
  localparam int IDX_W     = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_excl,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              upg_done,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [IDX_W-1:0]  q_idx,
  output logic              wr_hit,
  output logic              upg_req,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic [2:0]        q_state,
  output logic [3:0]        q_attr
);

  line_ev_t          ev_sel;
  logic [IDX_W-1:0]  ev_idx;
  logic [LINE_W-1:0] ev_wdata;
  line_st_t          cur_st, nxt_st, q_st;
  line_st_t          line_st_all [LINES];
  logic [LINE_W-1:0] cur_data;
  logic              supply, hit, upg_issue, data_we;

  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [LINE_W-1:0] pend_data_q;

  // One event per cycle, fixed priority
  always_comb begin
    ev_sel   = EV_NONE;
    ev_idx   = '0;
    ev_wdata = wr_data;
    if (snp_valid) begin
      ev_sel = EV_SNOOP;
      ev_idx = snp_idx;
    end else if (upg_done && pend_q) begin
      ev_sel   = EV_UPG_DONE;
      ev_idx   = pend_idx_q;
      ev_wdata = pend_data_q;
    end else if (fill_valid) begin
      ev_sel   = EV_FILL;
      ev_idx   = fill_idx;
      ev_wdata = fill_data;
    end else if (wr_valid && !pend_q) begin
      ev_sel = EV_WRITE;
      ev_idx = wr_idx;
    end
  end

  moesi_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .st_we   (ev_sel != EV_NONE),
    .w_idx   (ev_idx),
    .st_wval (nxt_st),
    .d_we    (data_we),
    .d_wdata (ev_wdata),
    .rd_idx  (ev_idx),
    .rd_st   (cur_st),
    .rd_data (cur_data),
    .q_idx   (q_idx),
    .q_st    (q_st),
    .st_all  (line_st_all)
  );

  moesi_next_state u_next (
    .cur       (cur_st),
    .ev        (ev_sel),
    .kind      (snoop_kind_t'(snp_kind)),
    .excl      (fill_excl),
    .nxt       (nxt_st),
    .supply    (supply),
    .hit       (hit),
    .upg_issue (upg_issue),
    .data_we   (data_we)
  );

  moesi_rsp_delay #(.DEPTH(RESP_DELAY), .W(LINE_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (supply),
    .in_data   (cur_data),
    .out_valid (rsp_valid),
    .out_data  (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      wr_hit  <= 1'b0;
      upg_req <= 1'b0;
    end else begin
      wr_hit  <= hit;
      upg_req <= upg_issue;
      if (upg_issue)                pend_q <= 1'b1;
      else if (ev_sel == EV_UPG_DONE) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upg_issue) begin
      pend_idx_q  <= ev_idx;
      pend_data_q <= wr_data;
    end
  end

  assign q_state = q_st;
  assign q_attr  = st_attr(q_st);

endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk
  import moesi_pkg::*;
#(
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input line_ev_t         ev,
  input logic [1:0]       kind,
  input logic [IDX_W-1:0] s_idx,
  input logic [IDX_W-1:0] f_idx,
  input logic             f_excl,
  input line_st_t         line_st [LINES],
  input logic             hit_o,
  input logic             upg_o,
  input logic             pend
);

  assert_hit_or_upgrade_R4: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && upg_o));

  assert_upgrade_marks_pending_R5: assert property (@(posedge clk) disable iff (rst)
    upg_o |-> pend);

  assert_fill_state_R3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_FILL) |=>
      (line_st[$past(f_idx)] == ($past(f_excl) ? LS_EXC : LS_SHD)));

  assert_shared_snoop_mod_to_own_R7: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_SNOOP && kind == 2'd0 && line_st[s_idx] == LS_MOD) |=>
      (line_st[$past(s_idx)] == LS_OWN));

  assert_excl_snoop_invalidates_R8: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_SNOOP && kind == 2'd2) |=> (line_st[$past(s_idx)] == LS_INV));

  assert_upgrade_snoop_invalidates_R9: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_SNOOP && kind == 2'd1) |=> (line_st[$past(s_idx)] == LS_INV));

endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev      (ev_sel),
  .kind    (snp_kind),
  .s_idx   (snp_idx),
  .f_idx   (fill_idx),
  .f_excl  (fill_excl),
  .line_st (line_st_all),
  .hit_o   (wr_hit),
  .upg_o   (upg_req),
  .pend    (pend_q)
);

// File: tb/moesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_test;

  localparam int LINES = 4;
  localparam int LW    = 64;
  localparam int D     = 3;
  localparam int IW    = $clog2(LINES);

  localparam logic [2:0] OP_FILL = 3'd0, OP_WR = 3'd1, OP_UPG = 3'd2, OP_SNP = 3'd3;
  localparam logic [2:0] SI = 3'd0, SS = 3'd1, SE = 3'd2, SO = 3'd3, SM = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  idx;
    logic [1:0]  kind;
    logic [15:0] arg;
    logic [2:0]  est;
    logic        ehit;
    logic        eupg;
    logic        ersp;
    logic [15:0] edat;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{OP_FILL, 2'd0, 2'd0, 16'hA1A1, SS, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd0, 2'd0, 16'h0000, SS, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_WR,   2'd0, 2'd0, 16'hB2B2, SS, 1'b0, 1'b1, 1'b0, 16'h0000},
    '{OP_UPG,  2'd0, 2'd0, 16'h0000, SM, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd0, 2'd0, 16'h0000, SO, 1'b0, 1'b0, 1'b1, 16'hB2B2},
    '{OP_SNP,  2'd0, 2'd0, 16'h0000, SO, 1'b0, 1'b0, 1'b1, 16'hB2B2},
    '{OP_SNP,  2'd0, 2'd2, 16'h0000, SI, 1'b0, 1'b0, 1'b1, 16'hB2B2},
    '{OP_FILL, 2'd1, 2'd1, 16'hC3C3, SE, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_WR,   2'd1, 2'd0, 16'hD4D4, SM, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{OP_WR,   2'd1, 2'd0, 16'hE5E5, SM, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd1, 2'd2, 16'h0000, SI, 1'b0, 1'b0, 1'b1, 16'hE5E5},
    '{OP_FILL, 2'd2, 2'd1, 16'hF6F6, SE, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd2, 2'd0, 16'h0000, SS, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd2, 2'd1, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_FILL, 2'd3, 2'd1, 16'h1111, SE, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd3, 2'd2, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_WR,   2'd3, 2'd0, 16'h7777, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd3, 2'd0, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_FILL, 2'd2, 2'd0, 16'h2222, SS, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd2, 2'd2, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_FILL, 2'd1, 2'd1, 16'h3333, SE, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_WR,   2'd1, 2'd0, 16'h4444, SM, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd1, 2'd0, 16'h0000, SO, 1'b0, 1'b0, 1'b1, 16'h4444},
    '{OP_WR,   2'd1, 2'd0, 16'h5555, SO, 1'b0, 1'b1, 1'b0, 16'h0000},
    '{OP_UPG,  2'd1, 2'd0, 16'h0000, SM, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd1, 2'd1, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_FILL, 2'd0, 2'd0, 16'h8888, SS, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{OP_SNP,  2'd0, 2'd1, 16'h0000, SI, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          fill_valid, fill_excl, wr_valid, upg_done, snp_valid;
  logic [IW-1:0] fill_idx, wr_idx, snp_idx, q_idx;
  logic [LW-1:0] fill_data, wr_data, rsp_data;
  logic [1:0]    snp_kind;
  logic          wr_hit, upg_req, rsp_valid;
  logic [2:0]    q_state;
  logic [3:0]    q_attr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  moesi_snoop_ctrl #(.LINES(LINES), .LINE_W(LW), .RESP_DELAY(D)) uut (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_excl(fill_excl), .fill_data(fill_data),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .upg_done(upg_done),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_idx(snp_idx),
    .q_idx(q_idx),
    .wr_hit(wr_hit), .upg_req(upg_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .q_state(q_state), .q_attr(q_attr)
  );

  function automatic logic [3:0] exp_attr(logic [2:0] s);
    case (s)
      SM:      return 4'b1111;
      SO:      return 4'b1011;
      SE:      return 4'b1110;
      SS:      return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] op, logic [1:0] kind);
    if (op == OP_FILL) return "R3";
    if (op == OP_WR)   return "R4/R5/R6";
    if (op == OP_UPG)  return "R5";
    if (kind == 2'd0)  return "R7";
    if (kind == 2'd1)  return "R9";
    return "R8";
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fill_valid = 1'b0; fill_excl = 1'b0; wr_valid = 1'b0; upg_done = 1'b0;
    snp_valid = 1'b0; snp_kind = 2'd0;
    fill_idx = '0; wr_idx = '0; snp_idx = '0;
    fill_data = '0; wr_data = '0;
  endtask

  // Drive one event before a rising edge; returns just after that edge.
  task automatic pulse(logic [2:0] op, logic [1:0] idx, logic [1:0] kind, logic [15:0] arg);
    @(negedge clk);
    case (op)
      OP_FILL: begin fill_valid = 1'b1; fill_idx = idx; fill_excl = kind[0]; fill_data = {4{arg}}; end
      OP_WR:   begin wr_valid = 1'b1; wr_idx = idx; wr_data = {4{arg}}; end
      OP_UPG:  upg_done = 1'b1;
      default: begin snp_valid = 1'b1; snp_idx = idx; snp_kind = kind; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  // Wait the remaining edges of the response window and check it.
  task automatic check_rsp(string req, logic erp, logic [15:0] edat);
    for (int i = 1; i < D; i++) begin
      if (i > 1) chk("R10", "early rsp_valid", 64'(rsp_valid), 64'd0);
      @(negedge clk);
    end
    chk(req, "rsp_valid", 64'(rsp_valid), 64'(erp));
    if (erp) chk("R10", "rsp_data", rsp_data, {4{edat}});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    q_idx = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every line and the outputs
    for (int l = 0; l < LINES; l++) begin
      q_idx = IW'(l);
      @(negedge clk);
      chk("R1", "q_state after reset", 64'(q_state), 64'(SI));
    end
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1", "wr_hit after reset", 64'(wr_hit), 64'd0);
    chk("R1", "upg_req after reset", 64'(upg_req), 64'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      string t;
      t = tag_of(VECS[v].op, VECS[v].kind);
      pulse(VECS[v].op, VECS[v].idx, VECS[v].kind, VECS[v].arg);
      chk(t, "wr_hit", 64'(wr_hit), 64'(VECS[v].ehit));
      chk(t, "upg_req", 64'(upg_req), 64'(VECS[v].eupg));
      q_idx = VECS[v].idx;
      check_rsp(t, VECS[v].ersp, VECS[v].edat);
      chk(t, "q_state", 64'(q_state), 64'(VECS[v].est));
      chk("R2", "q_attr", 64'(q_attr), 64'(exp_attr(VECS[v].est)));
      @(negedge clk);
      chk("R10", "rsp_valid single cycle", 64'(rsp_valid), 64'd0);
    end

    // R6: a write while an upgrade is pending is dropped
    pulse(OP_FILL, 2'd2, 2'd0, 16'h9999);
    pulse(OP_WR, 2'd2, 2'd0, 16'hAAAA);
    chk("R5", "upg_req on write to S", 64'(upg_req), 64'd1);
    pulse(OP_WR, 2'd2, 2'd0, 16'hBBBB);
    chk("R6", "wr_hit while pending", 64'(wr_hit), 64'd0);
    chk("R6", "upg_req while pending", 64'(upg_req), 64'd0);
    q_idx = 2'd2;
    @(negedge clk);
    chk("R5", "state held until upg_done", 64'(q_state), 64'(SS));
    pulse(OP_UPG, 2'd0, 2'd0, 16'h0000);
    @(negedge clk);
    chk("R5", "state after upg_done", 64'(q_state), 64'(SM));
    pulse(OP_SNP, 2'd2, 2'd0, 16'h0000);
    check_rsp("R6", 1'b1, 16'hAAAA);

    // R11: snoop and fill together, the fill is dropped
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = 2'd3; fill_excl = 1'b1; fill_data = {4{16'hCCCC}};
    snp_valid = 1'b1; snp_idx = 2'd0; snp_kind = 2'd0;
    @(negedge clk);
    idle_inputs();
    q_idx = 2'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "fill dropped under snoop", 64'(q_state), 64'(SI));

    // R11: upgrade completion beats a fill in the same cycle
    pulse(OP_FILL, 2'd1, 2'd0, 16'h1212);
    pulse(OP_WR, 2'd1, 2'd0, 16'h3434);
    @(negedge clk);
    upg_done = 1'b1;
    fill_valid = 1'b1; fill_idx = 2'd3; fill_excl = 1'b0; fill_data = {4{16'hDDDD}};
    @(negedge clk);
    idle_inputs();
    q_idx = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "upgrade completed", 64'(q_state), 64'(SM));
    q_idx = 2'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "fill dropped under upg_done", 64'(q_state), 64'(SI));

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule